// File: doc/BRIEF.md
# Fetch Address Control-Flow Checker

This block watches the instruction fetch stream of a pipelined processor from outside the core. On every fetch strobe it looks at the requested address together with the decoded class of the instruction found there, and it checks that the address is a legal successor of the previous accepted fetch. Each branch fetch also places an expectation into a small circular store. When the pipeline later reports the resolved program counter of that branch, the block compares it against the oldest pending expectation. Any violation sets a sticky error flag. The block never changes the fetch, never redirects it and never recovers from it. Its only other effect is a nop indication when the same address is fetched twice in a row.

The fetch-stream tracker is a three-state machine. ST_IDLE means there is no reference address (after reset, or after a misaligned fetch), so any fetch is accepted. ST_SEQ means the last accepted fetch was a non-branch, so only that address plus 4 is legal. ST_FORK means the last accepted fetch was a branch, so that address plus 4 and the in-word target are both legal. Any accepted aligned fetch moves the machine to ST_SEQ (non-branch or reserved class) or to ST_FORK (either branch class). An accepted misaligned fetch moves it to ST_IDLE. A repeated fetch is not accepted and leaves the state where it is. The pending store holds four entries by default. Its depth must be a power of two.

Top module: `cfc_monitor`

## Requirements
- R1: After reset `err_o`, `ovf_o` and `nop_o` are low and every pending entry is invalid.
- R2: A fetch whose address bits [1:0] are not 00 sets `err_o` from the next cycle on.
- R3: After an accepted fetch at A of class 00 (plain) or 11 (reserved, treated as plain), the next distinct fetch must be at A+4. Any other address sets `err_o`.
- R4: A fetch at the same address as the previous accepted fetch raises `nop_o` combinationally in that cycle. It sets no error, stores nothing and leaves the reference address and state unchanged.
- R5: After an accepted fetch at A of class 01 (conditional) or 10 (unconditional) with in-word target T, the next distinct fetch may be A+4 or T. Any other address sets `err_o`.
- R6: Each accepted aligned branch fetch stores one expectation. Resolved program counter reports (`pc_vld_i`) are compared with pending entries oldest first. A conditional entry accepts T or A+4. An unconditional entry accepts only T. A mismatch sets `err_o`, and the compared entry is released either way.
- R7: A resolved program counter report that arrives while no entry is pending is ignored.
- R8: A branch fetch that arrives while all entries are pending (with no release in the same cycle) sets `ovf_o` and is not stored. The older entries are kept intact.
- R9: `err_o` and `ovf_o` stay set until `clr_i` is high for a cycle. An error event in the same cycle as `clr_i` leaves the flag set.
- R10: The first fetch after reset is accepted at any aligned address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Synchronous clear of the sticky flags |
| fetch_vld_i | input | 1 | Fetch strobe |
| fetch_addr_i | input | AW | Fetch address |
| fetch_cls_i | input | 2 | Class of fetched instruction: 00 plain, 01 conditional, 10 unconditional, 11 reserved |
| fetch_tgt_i | input | AW | In-word branch target of the fetched instruction |
| pc_vld_i | input | 1 | Resolved branch program counter is valid |
| pc_i | input | AW | Resolved program counter of the oldest outstanding branch |
| nop_o | output | 1 | Repeated fetch: substitute a nop |
| err_o | output | 1 | Sticky control-flow error |
| ovf_o | output | 1 | Sticky pending-store overflow |

## Verification
The properties assume that each fetch strobe and each resolved-PC report lasts a single cycle and carries stable class and target values. They also assume that the pipeline reports exactly one resolved program counter per stored branch, in fetch order. The stimulus drives every strobe for exactly one cycle, separated by idle cycles. It issues resolution reports only in branch order, except where it deliberately sends them out of order or with nothing pending to provoke a mismatch or an ignored report. Address sweeps around a fixed reference cover every aligned and half-aligned offset in a window, so the sequential, repeat and misaligned cases all come from the same arithmetic.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
    typedef enum logic [1:0] {
        CLS_PLAIN = 2'b00,
        CLS_COND  = 2'b01,
        CLS_JUMP  = 2'b10,
        CLS_RSVD  = 2'b11
    } icls_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_SEQ  = 2'b01,
        ST_FORK = 2'b10
    } fstate_e;
endpackage

// File: rtl/cfc_seqchk.sv
module cfc_seqchk
    import cfc_pkg::*;
#(
    parameter int AW  = 16,
    parameter int ISZ = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_vld_i,
    input  logic [AW-1:0] fetch_addr_i,
    input  logic [1:0]    fetch_cls_i,
    input  logic [AW-1:0] fetch_tgt_i,
    output logic          nop_o,
    output logic          err_evt_o,
    output logic          push_o,
    output logic          push_cond_o,
    output logic [AW-1:0] push_tgt_o,
    output logic [AW-1:0] push_alt_o
);
    localparam logic [AW-1:0] STEP = AW'(ISZ);

    fstate_e       state_q, state_d;
    logic [AW-1:0] prev_q;
    logic [AW-1:0] fork_q;
    icls_e         cls;
    logic          rep, misal, seq_ok, bad, acc;

    assign cls = icls_e'(fetch_cls_i);

    // state and reference registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            prev_q  <= '0;
            fork_q  <= '0;
        end else begin
            state_q <= state_d;
            if (acc) begin
                prev_q <= fetch_addr_i;
                fork_q <= fetch_tgt_i;
            end
        end
    end

    // next state and outputs
    always_comb begin
        rep    = fetch_vld_i && (state_q != ST_IDLE) && (fetch_addr_i == prev_q);
        misal  = fetch_addr_i[1:0] != 2'b00;
        seq_ok = fetch_addr_i == (prev_q + STEP);
        acc    = fetch_vld_i && !rep;
        unique case (state_q)
            ST_IDLE: bad = 1'b0;
            ST_SEQ:  bad = !seq_ok;
            ST_FORK: bad = !(seq_ok || fetch_addr_i == fork_q);
            default: bad = 1'b0;
        endcase
        state_d = state_q;
        if (acc) begin
            if (misal) begin
                state_d = ST_IDLE;
            end else begin
                unique case (cls)
                    CLS_COND, CLS_JUMP: state_d = ST_FORK;
                    CLS_PLAIN, CLS_RSVD: state_d = ST_SEQ;
                    default: state_d = ST_SEQ;
                endcase
            end
        end
        nop_o       = rep;
        err_evt_o   = acc && (misal || bad);
        push_o      = acc && !misal && (cls == CLS_COND || cls == CLS_JUMP);
        push_cond_o = cls == CLS_COND;
        push_tgt_o  = fetch_tgt_i;
        push_alt_o  = fetch_addr_i + STEP;
    end
endmodule

// File: rtl/cfc_expq.sv
module cfc_expq #(
    parameter int AW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          push_cond_i,
    input  logic [AW-1:0] push_tgt_i,
    input  logic [AW-1:0] push_alt_i,
    input  logic          res_vld_i,
    input  logic [AW-1:0] res_pc_i,
    output logic          mismatch_o,
    output logic          overflow_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0]    tgt_q [DEPTH];
    logic [AW-1:0]    alt_q [DEPTH];
    logic [DEPTH-1:0] cond_q, vld_q;
    logic [PW-1:0]    wr_q, rd_q;
    logic             pop, slot_free, wr_en, hit;

    always_comb begin
        pop        = res_vld_i && vld_q[rd_q];
        slot_free  = !vld_q[wr_q] || (pop && rd_q == wr_q);
        wr_en      = push_i && slot_free;
        overflow_o = push_i && !slot_free;
        hit        = (res_pc_i == tgt_q[rd_q]) ||
                     (cond_q[rd_q] && res_pc_i == alt_q[rd_q]);
        mismatch_o = pop && !hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= '0;
            rd_q   <= '0;
            vld_q  <= '0;
            cond_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                tgt_q[i] <= '0;
                alt_q[i] <= '0;
            end
        end else begin
            if (wr_en) wr_q <= wr_q + PW'(1);
            if (pop)   rd_q <= rd_q + PW'(1);
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_en && wr_q == PW'(i)) begin
                    vld_q[i]  <= 1'b1;
                    cond_q[i] <= push_cond_i;
                    tgt_q[i]  <= push_tgt_i;
                    alt_q[i]  <= push_alt_i;
                end else if (pop && rd_q == PW'(i)) begin
                    vld_q[i] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/cfc_monitor.sv
module cfc_monitor #(
    parameter int AW    = 16,
    parameter int DEPTH = 4,
    parameter int ISZ   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          fetch_vld_i,
    input  logic [AW-1:0] fetch_addr_i,
    input  logic [1:0]    fetch_cls_i,
    input  logic [AW-1:0] fetch_tgt_i,
    input  logic          pc_vld_i,
    input  logic [AW-1:0] pc_i,
    output logic          nop_o,
    output logic          err_o,
    output logic          ovf_o
);
    logic          seq_err, mism, ovf_evt;
    logic          push, push_cond;
    logic [AW-1:0] push_tgt, push_alt;

    cfc_seqchk #(.AW(AW), .ISZ(ISZ)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_vld_i (fetch_vld_i),
        .fetch_addr_i(fetch_addr_i),
        .fetch_cls_i (fetch_cls_i),
        .fetch_tgt_i (fetch_tgt_i),
        .nop_o       (nop_o),
        .err_evt_o   (seq_err),
        .push_o      (push),
        .push_cond_o (push_cond),
        .push_tgt_o  (push_tgt),
        .push_alt_o  (push_alt)
    );

    cfc_expq #(.AW(AW), .DEPTH(DEPTH)) q_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .push_cond_i(push_cond),
        .push_tgt_i (push_tgt),
        .push_alt_i (push_alt),
        .res_vld_i  (pc_vld_i),
        .res_pc_i   (pc_i),
        .mismatch_o (mism),
        .overflow_o (ovf_evt)
    );

    // sticky flags: a new event outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o <= 1'b0;
            ovf_o <= 1'b0;
        end else begin
            err_o <= (err_o && !clr_i) || seq_err || mism;
            ovf_o <= (ovf_o && !clr_i) || ovf_evt;
        end
    end
endmodule

// File: rtl/cfc_monitor_chk.sv
module cfc_monitor_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr_i,
    input logic          fetch_vld_i,
    input logic [AW-1:0] fetch_addr_i,
    input logic          pc_vld_i,
    input logic          nop_o,
    input logic          err_o,
    input logic          ovf_o
);
    // R2
    misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_vld_i && fetch_addr_i[1:0] != 2'b00 |=> err_o);

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o && !clr_i |=> err_o);

    // R9
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o && !clr_i |=> ovf_o);

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !fetch_vld_i && !pc_vld_i |=> !err_o && !ovf_o);

    // R4
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nop_o && !pc_vld_i && !err_o |=> !err_o);

    // R4
    nop_on_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nop_o |-> fetch_vld_i);
endmodule

bind cfc_monitor cfc_monitor_chk #(.AW(AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .fetch_vld_i (fetch_vld_i),
    .fetch_addr_i(fetch_addr_i),
    .pc_vld_i    (pc_vld_i),
    .nop_o       (nop_o),
    .err_o       (err_o),
    .ovf_o       (ovf_o)
);

// File: tb/cfc_monitor_tb.sv
`timescale 1ns/1ps
module cfc_monitor_tb_top;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr_i = 1'b0;
    logic          fetch_vld_i = 1'b0;
    logic [AW-1:0] fetch_addr_i = '0;
    logic [1:0]    fetch_cls_i = 2'b00;
    logic [AW-1:0] fetch_tgt_i = '0;
    logic          pc_vld_i = 1'b0;
    logic [AW-1:0] pc_i = '0;
    logic          nop_o, err_o, ovf_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit nop_seen;

    always #4 clk = ~clk;

    cfc_monitor #(.AW(AW), .DEPTH(4), .ISZ(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
        .fetch_vld_i(fetch_vld_i), .fetch_addr_i(fetch_addr_i),
        .fetch_cls_i(fetch_cls_i), .fetch_tgt_i(fetch_tgt_i),
        .pc_vld_i(pc_vld_i), .pc_i(pc_i),
        .nop_o(nop_o), .err_o(err_o), .ovf_o(ovf_o)
    );

    task automatic chk(input bit got, input bit exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, got, exp);
        end
    endtask

    task automatic hard_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fetch(input logic [AW-1:0] a, input logic [1:0] c,
                         input logic [AW-1:0] t);
        @(negedge clk);
        fetch_vld_i = 1'b1; fetch_addr_i = a; fetch_cls_i = c; fetch_tgt_i = t;
        #1 nop_seen = nop_o;
        @(negedge clk);
        fetch_vld_i = 1'b0;
    endtask

    task automatic resolve(input logic [AW-1:0] v);
        @(negedge clk);
        pc_vld_i = 1'b1; pc_i = v;
        @(negedge clk);
        pc_vld_i = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
    endtask

    initial begin
        hard_reset();
        // R1 reset values
        chk(err_o, 1'b0, "R1 err after reset");
        chk(ovf_o, 1'b0, "R1 ovf after reset");
        chk(nop_o, 1'b0, "R1 nop after reset");
        // R7 report with nothing pending
        resolve(16'h1234);
        chk(err_o, 1'b0, "R7 empty report ignored");
        // R10 first fetch anywhere aligned
        fetch(16'h3000, 2'b00, '0);
        chk(err_o, 1'b0, "R10 first fetch accepted");

        // R3 / R2 / R4 sweep of offsets around a plain reference
        for (int off = -8; off <= 16; off += 2) begin
            hard_reset();
            fetch(16'h0100, 2'b00, '0);
            fetch(AW'(32'h100 + off), 2'b00, '0);
            chk(nop_seen, off == 0, $sformatf("R4 nop off=%0d", off));
            chk(err_o, (off != 0) && (off != 4), $sformatf("R3 seq off=%0d", off));
        end
        // R3 reserved class behaves as plain
        for (int off = 4; off <= 8; off += 4) begin
            hard_reset();
            fetch(16'h0100, 2'b11, 16'h0800);
            fetch(AW'(32'h100 + off), 2'b00, '0);
            chk(err_o, off != 4, $sformatf("R3 reserved off=%0d", off));
        end
        // R4 repeat leaves reference unchanged
        hard_reset();
        fetch(16'h0100, 2'b00, '0);
        fetch(16'h0100, 2'b00, '0);
        fetch(16'h0104, 2'b00, '0);
        chk(err_o, 1'b0, "R4 reference kept after repeat");

        // R5 branch successors
        for (int c = 1; c <= 2; c++) begin
            for (int k = 0; k < 4; k++) begin
                logic [AW-1:0] nx;
                nx = (k == 0) ? 16'h0104 : (k == 1) ? 16'h0200 :
                     (k == 2) ? 16'h0108 : 16'h01FC;
                hard_reset();
                fetch(16'h0100, 2'(c), 16'h0200);
                fetch(nx, 2'b00, '0);
                chk(err_o, k >= 2, $sformatf("R5 cls=%0d next=%h", c, nx));
            end
        end

        // R6 conditional accepts target or fall-through
        for (int k = 0; k < 3; k++) begin
            logic [AW-1:0] pv;
            pv = (k == 0) ? 16'h0200 : (k == 1) ? 16'h0104 : 16'h0108;
            hard_reset();
            fetch(16'h0100, 2'b01, 16'h0200);
            resolve(pv);
            chk(err_o, k == 2, $sformatf("R6 cond pc=%h", pv));
        end
        // R6 unconditional accepts only target
        for (int k = 0; k < 2; k++) begin
            hard_reset();
            fetch(16'h0100, 2'b10, 16'h0300);
            resolve(k == 0 ? 16'h0300 : 16'h0104);
            chk(err_o, k == 1, $sformatf("R6 jump k=%0d", k));
        end
        // R6 oldest first
        hard_reset();
        fetch(16'h0100, 2'b10, 16'h0300);
        fetch(16'h0300, 2'b10, 16'h0400);
        resolve(16'h0300);
        resolve(16'h0400);
        chk(err_o, 1'b0, "R6 in-order resolution");
        hard_reset();
        fetch(16'h0100, 2'b10, 16'h0300);
        fetch(16'h0300, 2'b10, 16'h0400);
        resolve(16'h0400);
        chk(err_o, 1'b1, "R6 out-of-order resolution");

        // R8 overflow
        hard_reset();
        for (int i = 1; i <= 4; i++)
            fetch(AW'(i * 256), 2'b10, AW'((i + 1) * 256));
        chk(ovf_o, 1'b0, "R8 four pending no overflow");
        fetch(16'h0500, 2'b10, 16'h0600);
        chk(ovf_o, 1'b1, "R8 fifth overflows");
        chk(err_o, 1'b0, "R8 overflow is not a flow error");
        for (int i = 2; i <= 5; i++) resolve(AW'(i * 256));
        chk(err_o, 1'b0, "R8 older entries intact");
        resolve(16'h0777);
        chk(err_o, 1'b0, "R8 fifth not stored");

        // R9 sticky and clear
        hard_reset();
        fetch(16'h0102, 2'b00, '0);
        chk(err_o, 1'b1, "R2 misaligned first fetch");
        repeat (3) @(negedge clk);
        chk(err_o, 1'b1, "R9 err sticky");
        chk(ovf_o, 1'b0, "R9 ovf untouched");
        clear();
        chk(err_o, 1'b0, "R9 clear err");
        @(negedge clk);
        clr_i = 1'b1; fetch_vld_i = 1'b1; fetch_addr_i = 16'h0206;
        @(negedge clk);
        clr_i = 1'b0; fetch_vld_i = 1'b0;
        chk(err_o, 1'b1, "R9 event beats clear");
        clear();
        chk(ovf_o, 1'b0, "R9 clear ovf");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule